// File: doc/BRIEF.md
# Ineffectual Instruction Removal Predictor

This block learns, from the retirement stream of a trailing thread that executes every instruction, which static instructions keep producing no visible result. A store that leaves memory unchanged, a register write that is overwritten before anything reads it, and a branch that the predictor got right all count as evidence of no effect. Each piece of evidence raises a small saturating confidence counter held for that instruction address. Any retirement of the same address that did have an effect resets the counter.

A leading thread runs a shortened version of the program. Its fetch stage presents each fetch address on a lookup port. The block answers in the same cycle whether that instruction may be skipped, which it allows only once the counter has saturated. When the trailing thread sees a branch or value misprediction caused by a wrong removal, the recovery logic sends the offending address on a flush input, and that address loses its confidence.

Dead register writes are detected inside the block. For every architectural register it keeps the address of the last writer and a flag recording whether that value has been read since it was written.

Top module: `ineff_skip_pred`

## Requirements
- R1: After reset, no lookup address reports skip.
- R2: A retirement of kind store (`ret_kind` = 2'b10) with `ret_silent` high raises the confidence of its address by one. Skip for that address is reported only after seven such indications in a row. Six are not enough.
- R3: A store retirement with `ret_silent` low clears the confidence of its address, so seven new silent indications are needed before skip returns.
- R4: A retirement of kind branch (`ret_kind` = 2'b11) raises confidence when `ret_pred_ok` is high and clears it when `ret_pred_ok` is low.
- R5: A retirement of kind register write (`ret_kind` = 2'b01) whose destination still holds an unread value written by an earlier instruction raises the confidence of that earlier instruction's address. The first write to a register after reset reports nothing.
- R6: If the previous value of a register was read by any retirement, including the overwriting instruction itself through `ret_rs1`/`ret_rs2`, then overwriting that register clears the previous writer's confidence. A retirement of kind none (2'b00) only records its reads and does not train.
- R7: A flush clears the confidence of the flushed address only. Other addresses keep their state.
- R8: When a flush and a training update target the same table slot in the same cycle, the flush wins and the counter ends at zero. When they target different slots, both take effect.
- R9: The table is direct-mapped with 64 slots indexed by address bits [7:2] and tagged with the bits above them. A lookup whose tag differs reports no skip. An increment for a new tag replaces the slot with a count of one.
- R10: The lookup is combinational on the current table. A training update becomes visible at the lookup port in the cycle after its retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ret_valid | input | 1 | A retirement record is present |
| ret_pc | input | PC_W | Address of the retiring instruction |
| ret_kind | input | 2 | 00 none, 01 register write, 10 store, 11 branch |
| ret_dst | input | log2(REG_N) | Destination register of a register write |
| ret_rs1_en | input | 1 | First source register is read |
| ret_rs1 | input | log2(REG_N) | First source register |
| ret_rs2_en | input | 1 | Second source register is read |
| ret_rs2 | input | log2(REG_N) | Second source register |
| ret_silent | input | 1 | Store wrote the value already present |
| ret_pred_ok | input | 1 | Branch outcome was predicted correctly |
| flush_valid | input | 1 | Removal misprediction recovery request |
| flush_pc | input | PC_W | Address whose removal was wrong |
| lk_pc | input | PC_W | Fetch address of the leading thread |
| lk_skip | output | 1 | Instruction at `lk_pc` may be skipped |

## Verification
Two functions can hit the same table slot in the same cycle: training from a retirement and clearing by a flush. The bench drives both in one cycle on one slot, after bringing that slot to saturation, and expects the lookup to show no skip in the next cycle. It then repeats the collision on two different slots, one just below saturation. It expects the trained slot to report skip and the flushed slot to report none. A second overlap, a lookup during the cycle that trains the same address, is judged by sampling the lookup before the clock edge (old value) and after it (new value).

// File: rtl/ineff_pkg.sv
package ineff_pkg;
   typedef enum logic [1:0] {
      K_NONE   = 2'b00,
      K_REGWR  = 2'b01,
      K_STORE  = 2'b10,
      K_BRANCH = 2'b11
   } ret_kind_e;
endpackage

// File: rtl/ineff_dead_track.sv
module ineff_dead_track #(
   parameter int PC_W   = 32,
   parameter int REG_N  = 32,
   parameter int REG_AW = $clog2(REG_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ret_valid,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] dst,
   input  logic              rs1_en,
   input  logic [REG_AW-1:0] rs1,
   input  logic              rs2_en,
   input  logic [REG_AW-1:0] rs2,
   input  logic [PC_W-1:0]   pc,
   output logic              rep_valid,
   output logic [PC_W-1:0]   rep_pc,
   output logic              rep_dead
);
   logic [REG_N-1:0]            own_q;
   logic [REG_N-1:0]            seen_q;
   logic [REG_N-1:0][PC_W-1:0]  wpc_q;
   logic                        self_read;

   assign self_read = (rs1_en && rs1 == dst) || (rs2_en && rs2 == dst);
   assign rep_valid = ret_valid && wr_en && own_q[dst];
   assign rep_pc    = wpc_q[dst];
   assign rep_dead  = !seen_q[dst] && !self_read;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q  <= '0;
         seen_q <= '0;
         wpc_q  <= '0;
      end else if (ret_valid) begin
         for (int r = 0; r < REG_N; r++) begin
            if (wr_en && dst == REG_AW'(r)) begin
               own_q[r]  <= 1'b1;
               seen_q[r] <= 1'b0;
               wpc_q[r]  <= pc;
            end else if ((rs1_en && rs1 == REG_AW'(r)) ||
                         (rs2_en && rs2 == REG_AW'(r))) begin
               seen_q[r] <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ineff_train.sv
module ineff_train
   import ineff_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic            ret_valid,
   input  logic [1:0]      ret_kind,
   input  logic [PC_W-1:0] ret_pc,
   input  logic            ret_silent,
   input  logic            ret_pred_ok,
   input  logic            rep_valid,
   input  logic [PC_W-1:0] rep_pc,
   input  logic            rep_dead,
   output logic            wr_en,
   output logic            tr_valid,
   output logic [PC_W-1:0] tr_pc,
   output logic            tr_inc
);
   ret_kind_e kind;
   assign kind  = ret_kind_e'(ret_kind);
   assign wr_en = (kind == K_REGWR);

   always_comb begin
      tr_valid = 1'b0;
      tr_pc    = ret_pc;
      tr_inc   = 1'b0;
      unique case (kind)
         K_STORE: begin
            tr_valid = ret_valid;
            tr_inc   = ret_silent;
         end
         K_BRANCH: begin
            tr_valid = ret_valid;
            tr_inc   = ret_pred_ok;
         end
         K_REGWR: begin
            tr_valid = rep_valid;
            tr_pc    = rep_pc;
            tr_inc   = rep_dead;
         end
         default: tr_valid = 1'b0;
      endcase
   end
endmodule

// File: rtl/ineff_conf_table.sv
module ineff_conf_table #(
   parameter int PC_W            = 32,
   parameter int IDX_W           = 6,
   parameter int CNT_W           = 3,
   parameter bit CLEAR_ON_EFFECT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tr_valid,
   input  logic [PC_W-1:0] tr_pc,
   input  logic            tr_inc,
   input  logic            fl_valid,
   input  logic [PC_W-1:0] fl_pc,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_skip
);
   localparam int ENTRIES = 1 << IDX_W;
   localparam int TAG_W   = PC_W - IDX_W - 2;
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [IDX_W-1:0] tr_idx, fl_idx, lk_idx;
   logic [TAG_W-1:0] tr_tag, fl_tag, lk_tag;

   assign tr_idx = tr_pc[IDX_W+1:2];
   assign fl_idx = fl_pc[IDX_W+1:2];
   assign lk_idx = lk_pc[IDX_W+1:2];
   assign tr_tag = tr_pc[PC_W-1:IDX_W+2];
   assign fl_tag = fl_pc[PC_W-1:IDX_W+2];
   assign lk_tag = lk_pc[PC_W-1:IDX_W+2];

   logic [ENTRIES-1:0]             e_v;
   logic [ENTRIES-1:0][TAG_W-1:0]  e_tag;
   logic [ENTRIES-1:0][CNT_W-1:0]  e_cnt;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      logic             v_q;
      logic [TAG_W-1:0] tag_q;
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] cnt_eff;
      logic             tr_sel, tr_own, fl_sel;

      assign tr_sel = tr_valid && (tr_idx == IDX_W'(e));
      assign tr_own = v_q && (tag_q == tr_tag);
      assign fl_sel = fl_valid && (fl_idx == IDX_W'(e)) && v_q && (tag_q == fl_tag);

      if (CLEAR_ON_EFFECT) begin : g_clr
         assign cnt_eff = '0;
      end else begin : g_dec
         assign cnt_eff = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q   <= 1'b0;
            tag_q <= '0;
            cnt_q <= '0;
         end else if (fl_sel) begin
            cnt_q <= '0;
         end else if (tr_sel) begin
            if (tr_own) begin
               if (!tr_inc)
                  cnt_q <= cnt_eff;
               else if (cnt_q != CNT_MAX)
                  cnt_q <= cnt_q + 1'b1;
            end else if (tr_inc) begin
               v_q   <= 1'b1;
               tag_q <= tr_tag;
               cnt_q <= CNT_W'(1);
            end
         end
      end

      assign e_v[e]   = v_q;
      assign e_tag[e] = tag_q;
      assign e_cnt[e] = cnt_q;
   end

   assign lk_skip = e_v[lk_idx] && (e_tag[lk_idx] == lk_tag) && (e_cnt[lk_idx] == CNT_MAX);
endmodule

// File: rtl/ineff_skip_pred.sv
module ineff_skip_pred #(
   parameter int PC_W            = 32,
   parameter int IDX_W           = 6,
   parameter int CNT_W           = 3,
   parameter int REG_N           = 32,
   parameter bit CLEAR_ON_EFFECT = 1'b1,
   localparam int REG_AW         = $clog2(REG_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ret_valid,
   input  logic [PC_W-1:0]   ret_pc,
   input  logic [1:0]        ret_kind,
   input  logic [REG_AW-1:0] ret_dst,
   input  logic              ret_rs1_en,
   input  logic [REG_AW-1:0] ret_rs1,
   input  logic              ret_rs2_en,
   input  logic [REG_AW-1:0] ret_rs2,
   input  logic              ret_silent,
   input  logic              ret_pred_ok,
   input  logic              flush_valid,
   input  logic [PC_W-1:0]   flush_pc,
   input  logic [PC_W-1:0]   lk_pc,
   output logic              lk_skip
);
   if (IDX_W < 1 || IDX_W + 3 > PC_W) begin : g_bad_idx
      $error("ineff_skip_pred: IDX_W must leave room for a tag");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("ineff_skip_pred: CNT_W must be at least 1");
   end
   if (REG_N < 2 || (1 << REG_AW) != REG_N) begin : g_bad_reg
      $error("ineff_skip_pred: REG_N must be a power of two");
   end

   logic            rep_valid, rep_dead, wr_en;
   logic [PC_W-1:0] rep_pc;
   logic            tr_valid, tr_inc;
   logic [PC_W-1:0] tr_pc;

   ineff_dead_track #(.PC_W(PC_W), .REG_N(REG_N), .REG_AW(REG_AW)) trk_i (
      .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .wr_en(wr_en),
      .dst(ret_dst), .rs1_en(ret_rs1_en), .rs1(ret_rs1),
      .rs2_en(ret_rs2_en), .rs2(ret_rs2), .pc(ret_pc),
      .rep_valid(rep_valid), .rep_pc(rep_pc), .rep_dead(rep_dead)
   );

   ineff_train #(.PC_W(PC_W)) trn_i (
      .ret_valid(ret_valid), .ret_kind(ret_kind), .ret_pc(ret_pc),
      .ret_silent(ret_silent), .ret_pred_ok(ret_pred_ok),
      .rep_valid(rep_valid), .rep_pc(rep_pc), .rep_dead(rep_dead),
      .wr_en(wr_en), .tr_valid(tr_valid), .tr_pc(tr_pc), .tr_inc(tr_inc)
   );

   ineff_conf_table #(.PC_W(PC_W), .IDX_W(IDX_W), .CNT_W(CNT_W),
                      .CLEAR_ON_EFFECT(CLEAR_ON_EFFECT)) tbl_i (
      .clk(clk), .rst_n(rst_n), .tr_valid(tr_valid), .tr_pc(tr_pc),
      .tr_inc(tr_inc), .fl_valid(flush_valid), .fl_pc(flush_pc),
      .lk_pc(lk_pc), .lk_skip(lk_skip)
   );
endmodule

// File: rtl/ineff_skip_pred_chk.sv
module ineff_skip_pred_chk #(
   parameter int PC_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ret_valid,
   input logic [PC_W-1:0] ret_pc,
   input logic [1:0]      ret_kind,
   input logic            ret_silent,
   input logic            ret_pred_ok,
   input logic            flush_valid,
   input logic [PC_W-1:0] flush_pc,
   input logic [PC_W-1:0] lk_pc,
   input logic            lk_skip
);
   AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !lk_skip); // R1

   AST_LOUD_STORE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && ret_kind == 2'b10 && !ret_silent)
      |=> !(lk_skip && lk_pc == $past(ret_pc))); // R3

   AST_MISSED_BRANCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && ret_kind == 2'b11 && !ret_pred_ok)
      |=> !(lk_skip && lk_pc == $past(ret_pc))); // R4

   AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |=> !(lk_skip && lk_pc == $past(flush_pc))); // R8

   AST_RISE_NEEDS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(lk_skip) && $stable(lk_pc)) |-> $past(ret_valid)); // R10
endmodule

bind ineff_skip_pred ineff_skip_pred_chk #(.PC_W(PC_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
   .ret_kind(ret_kind), .ret_silent(ret_silent), .ret_pred_ok(ret_pred_ok),
   .flush_valid(flush_valid), .flush_pc(flush_pc), .lk_pc(lk_pc),
   .lk_skip(lk_skip)
);

// File: tb/ineff_skip_pred_tb_top.sv
module ineff_skip_pred_tb_top;
   localparam int PC_W = 32;
   localparam int AW   = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ret_valid = 1'b0;
   logic [PC_W-1:0] ret_pc = '0;
   logic [1:0]      ret_kind = 2'b00;
   logic [AW-1:0]   ret_dst = '0;
   logic            ret_rs1_en = 1'b0;
   logic [AW-1:0]   ret_rs1 = '0;
   logic            ret_rs2_en = 1'b0;
   logic [AW-1:0]   ret_rs2 = '0;
   logic            ret_silent = 1'b0;
   logic            ret_pred_ok = 1'b0;
   logic            flush_valid = 1'b0;
   logic [PC_W-1:0] flush_pc = '0;
   logic [PC_W-1:0] lk_pc = '0;
   logic            lk_skip;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   localparam logic [PC_W-1:0] PA = 32'h100, PB = 32'h204, PW = 32'h308,
                               PX = 32'h40C, PC5 = 32'h510, PD = 32'h200,
                               PR = 32'h3F0;

   always #10 clk = ~clk;

   ineff_skip_pred dut_i (
      .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
      .ret_kind(ret_kind), .ret_dst(ret_dst), .ret_rs1_en(ret_rs1_en),
      .ret_rs1(ret_rs1), .ret_rs2_en(ret_rs2_en), .ret_rs2(ret_rs2),
      .ret_silent(ret_silent), .ret_pred_ok(ret_pred_ok),
      .flush_valid(flush_valid), .flush_pc(flush_pc), .lk_pc(lk_pc),
      .lk_skip(lk_skip)
   );

   task automatic check(input logic act, input logic exp, input string req, input string what);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   task automatic look(input logic [PC_W-1:0] pc, input logic exp, input string req, input string what);
      lk_pc = pc;
      #1;
      check(lk_skip, exp, req, what);
   endtask

   // one cycle of stimulus: set at negedge, released just after the posedge
   task automatic cyc(input logic rv, input logic [PC_W-1:0] pc, input logic [1:0] kind,
                      input logic [AW-1:0] dst, input logic r1en, input logic [AW-1:0] r1,
                      input logic silent, input logic ok,
                      input logic fv, input logic [PC_W-1:0] fpc);
      @(negedge clk);
      ret_valid = rv; ret_pc = pc; ret_kind = kind; ret_dst = dst;
      ret_rs1_en = r1en; ret_rs1 = r1; ret_silent = silent; ret_pred_ok = ok;
      flush_valid = fv; flush_pc = fpc;
      @(posedge clk);
      #1;
      ret_valid = 1'b0; flush_valid = 1'b0; ret_rs1_en = 1'b0;
   endtask

   task automatic st(input logic [PC_W-1:0] pc, input logic silent);
      cyc(1'b1, pc, 2'b10, '0, 1'b0, '0, silent, 1'b0, 1'b0, '0);
   endtask
   task automatic br(input logic [PC_W-1:0] pc, input logic ok);
      cyc(1'b1, pc, 2'b11, '0, 1'b0, '0, 1'b0, ok, 1'b0, '0);
   endtask
   task automatic wr(input logic [PC_W-1:0] pc, input logic [AW-1:0] dst,
                     input logic r1en, input logic [AW-1:0] r1);
      cyc(1'b1, pc, 2'b01, dst, r1en, r1, 1'b0, 1'b0, 1'b0, '0);
   endtask

   task automatic t_reset;
      look(PA, 1'b0, "R1", "A after reset");
      look(PB, 1'b0, "R1", "B after reset");
      look(32'h0, 1'b0, "R1", "zero after reset");
   endtask

   task automatic t_store;
      for (int i = 0; i < 6; i++) st(PA, 1'b1);
      look(PA, 1'b0, "R2", "six silent stores");
      // seventh store: lookup seen before and after the training edge
      @(negedge clk);
      ret_valid = 1'b1; ret_pc = PA; ret_kind = 2'b10; ret_silent = 1'b1;
      lk_pc = PA;
      #1;
      check(lk_skip, 1'b0, "R10", "lookup before training edge");
      @(posedge clk);
      #1;
      ret_valid = 1'b0;
      check(lk_skip, 1'b1, "R2", "seven silent stores");
      st(PA, 1'b0);
      look(PA, 1'b0, "R3", "non-silent store clears");
      for (int i = 0; i < 6; i++) st(PA, 1'b1);
      look(PA, 1'b0, "R3", "six stores after clear");
      st(PA, 1'b1);
      look(PA, 1'b1, "R3", "seventh store after clear");
   endtask

   task automatic t_branch;
      for (int i = 0; i < 7; i++) br(PB, 1'b1);
      look(PB, 1'b1, "R4", "seven correct branches");
      br(PB, 1'b0);
      look(PB, 1'b0, "R4", "mispredicted branch clears");
      for (int i = 0; i < 7; i++) br(PB, 1'b1);
      look(PB, 1'b1, "R4", "retrained branch");
   endtask

   task automatic t_dead;
      for (int i = 0; i < 7; i++) wr(PW, 5'd5, 1'b0, '0);
      look(PW, 1'b0, "R5", "six dead-write reports");
      wr(PW, 5'd5, 1'b0, '0);
      look(PW, 1'b1, "R5", "seven dead-write reports");
      cyc(1'b1, PR, 2'b00, '0, 1'b1, 5'd5, 1'b0, 1'b0, 1'b0, '0);
      look(PR, 1'b0, "R6", "kind none does not train");
      wr(PW, 5'd5, 1'b0, '0);
      look(PW, 1'b0, "R6", "read value overwritten clears writer");
      for (int i = 0; i < 9; i++) wr(PX, 5'd6, 1'b1, 5'd6);
      look(PX, 1'b0, "R6", "self-reading writer never dead");
   endtask

   task automatic t_flush;
      cyc(1'b0, '0, 2'b00, '0, 1'b0, '0, 1'b0, 1'b0, 1'b1, PA);
      look(PA, 1'b0, "R7", "flushed address cleared");
      look(PB, 1'b1, "R7", "other address kept");
   endtask

   task automatic t_collide;
      for (int i = 0; i < 7; i++) st(PA, 1'b1);
      look(PA, 1'b1, "R8", "A saturated before collision");
      cyc(1'b1, PA, 2'b10, '0, 1'b0, '0, 1'b1, 1'b0, 1'b1, PA);
      look(PA, 1'b0, "R8", "same slot flush beats training");
      for (int i = 0; i < 6; i++) st(PC5, 1'b1);
      cyc(1'b1, PC5, 2'b10, '0, 1'b0, '0, 1'b1, 1'b0, 1'b1, PB);
      look(PB, 1'b0, "R8", "flushed slot in split collision");
      look(PC5, 1'b1, "R8", "trained slot in split collision");
   endtask

   task automatic t_alias;
      for (int i = 0; i < 7; i++) st(PA, 1'b1);
      look(PA, 1'b1, "R9", "A saturated");
      look(PD, 1'b0, "R9", "same index other tag");
      st(PD, 1'b1);
      look(PA, 1'b0, "R9", "A replaced by new tag");
      look(PD, 1'b0, "R9", "new tag starts at one");
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset;
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      t_reset;
      t_store;
      t_branch;
      t_dead;
      t_flush;
      t_collide;
      t_alias;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule